// File: doc/BRIEF.md
# Card Punch Row Serializer

This controller feeds a card punch one row at a time. A card image sits in memory as ten consecutive 48-bit words, each packing eight 6-bit character codes, which gives eighty columns. For every row the punch works on, the controller reads all ten words again through a request/acknowledge port. It steps through the characters with a character counter and, for each one, decides whether the column needs a hole in the row the punch reports. That single decision bit goes out on a serial data line, framed by a clock pulse cut from a recycling tick counter.

A start strobe captures the base address and the stacker choice. The card then runs for twelve rows, each begun when the punch asks for information. A done pulse closes the card. If the punch reports an earlier error when start arrives, the controller skips the card and ends at once with an error flag.

Top module: `card_row_punch`

## Requirements
- R1: After reset, `punch_start`, `punch_clk`, `mem_req`, `done`, `last_row` and `card_err` are low. A `start` strobe while idle, with `punch_err` low, raises `punch_start` in the following cycle and captures `base_addr` and `stacker_in`.
- R2: A `start` strobe while idle with `punch_err` high makes no memory request and no clock pulse. `done` and `card_err` are high in the cycle after that start edge, and `punch_start` stays low.
- R3: Each row begins only on a rising edge of `punch_need` seen while the controller waits between rows. No memory request is made before that edge.
- R4: Within a row, words are fetched from `base`, `base+1` up to `base+9`, and every row restarts at `base`, so one card takes exactly 120 fetches. `mem_req` stays high with a stable `mem_addr` until `mem_ack` is seen.
- R5: Characters leave in order: bits [47:42] of a word first, bits [5:0] last, and words in address order. The first character of the first word is the first serial bit of a row. Each row is exactly 80 bits, and each bit is valid on `punch_data` when `punch_clk` rises.
- R6: For a character, the zone is bits [5:4] and the digit is bits [3:0]. Row code 12 punches when the zone is 3, row 11 when the zone is 2, and row 0 when the zone is 1. Row codes 1 to 9 punch when the digit equals the row code. Digit values 0 and 10 to 15 punch no digit row.
- R7: Row codes 10, 13, 14 and 15 produce 80 zero bits.
- R8: Each bit occupies one cycle of a pulse counter that advances on `tick` from 0 to 14 and then wraps. `punch_clk` is high while the count is 9, 10 or 11, which is exactly three ticks. `punch_data` is stable while `punch_clk` is high.
- R9: When the bit period (count 14) of the 80th bit of the twelfth row ends, `done` is high for exactly one cycle in the next cycle. At that point `last_row` is set and `punch_start` is low. With `tick` high every cycle, `done` is seen three cycles after `punch_clk` falls for that bit.
- R10: A `start` strobe while a card is in progress is ignored: the base address, the stacker output and `punch_start` are unchanged.
- R11: `stacker_sel` holds the captured stacker choice from start until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timing tick enable for the pulse counter |
| start | input | 1 | Start strobe for one card |
| base_addr | input | AW | Address of the first word of the card image |
| stacker_in | input | 1 | Stacker choice for this card |
| punch_err | input | 1 | Punch reports an error from an earlier card |
| punch_need | input | 1 | Punch asks for the next row |
| row_code | input | 4 | Binary code of the row being punched |
| mem_req | output | 1 | Memory word request |
| mem_addr | output | AW | Word address of the request |
| mem_ack | input | 1 | Memory returns the word |
| mem_rdata | input | 48 | Returned word |
| punch_start | output | 1 | Start-punch level for the card |
| punch_clk | output | 1 | Serial bit clock pulse |
| punch_data | output | 1 | Serial hole bit |
| stacker_sel | output | 1 | Held stacker choice |
| last_row | output | 1 | Set once the final row has been sent |
| card_err | output | 1 | Card ended on the error path |
| done | output | 1 | One-cycle end-of-card pulse |

## Verification
The embedded properties watch, on every cycle, that a memory request holds its address until acknowledged and stays inside the ten-word window. They also check that serial data does not move under a high clock pulse, that the stacker output is steady through a card, that `done` lasts one cycle, and that an error-ended card never fetches or clocks. The decode table, the character and word order, the per-row restart, the fetch count, the pulse width against the tick rate and the exact done latency can only be shown by the bench. It sweeps every character code through every valid and invalid row code at two tick rates and compares the captured serial bits with values computed from the requirements.

// File: rtl/card_row_punch.sv
module card_row_punch #(
  parameter int CHAR_W = 6,
  parameter int CHARS  = 8,
  parameter int WORDS  = 10,
  parameter int ROWS   = 12,
  parameter int AW     = 15,
  parameter int PC_MAX = 14,
  parameter int PC_ON  = 9,
  parameter int PC_OFF = 11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic                      start,
  input  logic [AW-1:0]             base_addr,
  input  logic                      stacker_in,
  input  logic                      punch_err,
  input  logic                      punch_need,
  input  logic [3:0]                row_code,
  output logic                      mem_req,
  output logic [AW-1:0]             mem_addr,
  input  logic                      mem_ack,
  input  logic [CHAR_W*CHARS-1:0]   mem_rdata,
  output logic                      punch_start,
  output logic                      punch_clk,
  output logic                      punch_data,
  output logic                      stacker_sel,
  output logic                      last_row,
  output logic                      card_err,
  output logic                      done
);
  localparam int WORD_W = CHAR_W * CHARS;
  localparam int CW = (CHARS > 1) ? $clog2(CHARS) : 1;
  localparam int WW = $clog2(WORDS + 1);
  localparam int RW = $clog2(ROWS + 1);
  localparam int PW = $clog2(PC_MAX + 1);
  localparam logic [PW-1:0] PC_LAST = PW'(PC_MAX);
  localparam logic [PW-1:0] PC_LO   = PW'(PC_ON);
  localparam logic [PW-1:0] PC_HI   = PW'(PC_OFF);
  localparam logic [CW-1:0] CH_LAST = CW'(CHARS - 1);
  localparam logic [WW-1:0] W_LOAD  = WW'(WORDS);
  localparam logic [RW-1:0] R_LAST  = RW'(ROWS - 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_FETCH, S_SHIFT, S_FIN} st_t;

  st_t               st;
  logic [AW-1:0]     base_q, addr_q;
  logic [WORD_W-1:0] wreg;
  logic [CW-1:0]     chr;
  logic [WW-1:0]     wleft;
  logic [RW-1:0]     rows_done;
  logic [PW-1:0]     pc;
  logic              need_q, obuf;

  function automatic logic hole(input logic [CHAR_W-1:0] ch, input logic [3:0] rc);
    logic [1:0] z;
    logic [3:0] d;
    z = ch[CHAR_W-1 -: 2];
    d = ch[3:0];
    if (rc == 4'd12)                      hole = (z == 2'b11);
    else if (rc == 4'd11)                 hole = (z == 2'b10);
    else if (rc == 4'd0)                  hole = (z == 2'b01);
    else if (rc >= 4'd1 && rc <= 4'd9)    hole = (d == rc);
    else                                  hole = 1'b0;
  endfunction

  wire need_rise = punch_need & ~need_q;

  assign mem_req    = (st == S_FETCH);
  assign mem_addr   = addr_q;
  assign punch_clk  = (st == S_SHIFT) && (pc >= PC_LO) && (pc <= PC_HI);
  assign punch_data = obuf;
  assign done       = (st == S_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      base_q      <= '0;
      addr_q      <= '0;
      wreg        <= '0;
      chr         <= '0;
      wleft       <= '0;
      rows_done   <= '0;
      pc          <= '0;
      need_q      <= 1'b0;
      obuf        <= 1'b0;
      punch_start <= 1'b0;
      stacker_sel <= 1'b0;
      last_row    <= 1'b0;
      card_err    <= 1'b0;
    end else begin
      need_q <= punch_need;
      case (st)
        S_IDLE: if (start) begin
          base_q      <= base_addr;
          stacker_sel <= stacker_in;
          last_row    <= 1'b0;
          card_err    <= punch_err;
          rows_done   <= '0;
          chr         <= '0;
          wleft       <= W_LOAD;
          if (punch_err) st <= S_FIN;
          else begin
            punch_start <= 1'b1;
            st          <= S_WAIT;
          end
        end
        S_WAIT: if (need_rise) begin
          addr_q <= base_q;
          wleft  <= W_LOAD;
          st     <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          wreg <= mem_rdata;
          chr  <= '0;
          pc   <= '0;
          obuf <= hole(mem_rdata[WORD_W-1 -: CHAR_W], row_code);
          st   <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          if (pc != PC_LAST) pc <= pc + 1'b1;
          else begin
            pc <= '0;
            if (chr != CH_LAST) begin
              chr  <= chr + 1'b1;
              wreg <= wreg << CHAR_W;
              obuf <= hole(wreg[WORD_W-CHAR_W-1 -: CHAR_W], row_code);
            end else if (wleft != WW'(1)) begin
              wleft  <= wleft - 1'b1;
              addr_q <= addr_q + 1'b1;
              st     <= S_FETCH;
            end else if (rows_done != R_LAST) begin
              rows_done <= rows_done + 1'b1;
              st        <= S_WAIT;
            end else begin
              last_row    <= 1'b1;
              punch_start <= 1'b0;
              st          <= S_FIN;
            end
          end
        end
        S_FIN: begin
          punch_start <= 1'b0;
          st          <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  // R4
  addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr - base_q) < AW'(WORDS));

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    punch_clk |=> !punch_clk || $stable(punch_data));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  stacker_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    punch_start && $past(punch_start) |-> $stable(stacker_sel));

  // R2
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_err |-> !mem_req && !punch_clk);

  // R5
  clk_in_card_chk: assert property (@(posedge clk) disable iff (!rst_n)
    punch_clk |-> punch_start);
endmodule

// File: tb/sim_card_row_punch.sv
module sim_card_row_punch;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, tick = 1'b0, start = 1'b0, stacker_in = 1'b0;
  logic        punch_err = 1'b0, punch_need = 1'b0, mem_ack = 1'b0;
  logic [14:0] base_addr = '0;
  logic [3:0]  row_code = '0;
  logic [47:0] mem_rdata = '0;
  logic        mem_req, punch_start, punch_clk, punch_data, stacker_sel, last_row, card_err, done;
  logic [14:0] mem_addr;

  card_row_punch u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .base_addr(base_addr),
    .stacker_in(stacker_in), .punch_err(punch_err), .punch_need(punch_need),
    .row_code(row_code), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .punch_start(punch_start), .punch_clk(punch_clk),
    .punch_data(punch_data), .stacker_sel(stacker_sel), .last_row(last_row),
    .card_err(card_err), .done(done)
  );

  int total = 0, bad = 0;
  int tdiv = 1, tcnt = 0, seed = 0, base_tb = 0;
  int fetch_cnt = 0, addr_bad = 0, idx = 0;
  int bitcnt = 0, hi_run = 0, width_bad = 0, fall_n = 0, done_lat = 0, done_cnt = 0;
  bit cap [80];
  logic prev_clk = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [5:0] chr_of(input int w, input int c, input int sd);
    return 6'((w * 8 + c + sd) % 64);
  endfunction

  function automatic logic [47:0] word_of(input int w, input int sd);
    logic [47:0] v = '0;
    for (int c = 0; c < 8; c++) v[47 - 6 * c -: 6] = chr_of(w, c, sd);
    return v;
  endfunction

  function automatic bit exp_hole(input logic [5:0] ch, input int rc);
    if (rc == 12) return ch[5:4] == 2'd3;
    if (rc == 11) return ch[5:4] == 2'd2;
    if (rc == 0)  return ch[5:4] == 2'd1;
    if (rc >= 1 && rc <= 9) return int'(ch[3:0]) == rc;
    return 1'b0;
  endfunction

  always @(negedge clk) begin
    tick <= (tcnt == 0);
    tcnt  = (tcnt + 1 >= tdiv) ? 0 : tcnt + 1;
    if (mem_req && !mem_ack) begin
      if (int'(mem_addr) != base_tb + fetch_cnt % 10) addr_bad++;
      idx = int'(mem_addr) - base_tb;
      mem_rdata <= (idx >= 0 && idx < 10) ? word_of(idx, seed) : '0;
      mem_ack   <= 1'b1;
      fetch_cnt++;
    end else mem_ack <= 1'b0;
    if (punch_clk && !prev_clk) begin
      if (bitcnt < 80) cap[bitcnt] = punch_data;
      bitcnt++;
      hi_run = 1;
    end else if (punch_clk) hi_run++;
    if (!punch_clk && prev_clk) begin
      if (hi_run != 3 * tdiv) width_bad++;
      fall_n = 0;
    end else fall_n++;
    if (done) begin
      done_cnt++;
      done_lat = fall_n;
    end
    prev_clk = punch_clk;
  end

  task automatic do_row(input int rc);
    int f0, mis;
    row_code = 4'(rc);
    bitcnt = 0;
    f0 = fetch_cnt;
    repeat (40) @(negedge clk);
    chk(fetch_cnt == f0, "R3 fetch before row request", fetch_cnt, f0);
    punch_need = 1'b1;
    repeat (2) @(negedge clk);
    punch_need = 1'b0;
    while (bitcnt < 80) @(negedge clk);
    mis = 0;
    for (int k = 0; k < 80; k++)
      if (cap[k] != exp_hole(chr_of(k / 8, k % 8, seed), rc)) mis++;
    if (rc <= 9 || rc == 11 || rc == 12) chk(mis == 0, "R6 R5 row bits mismatched", mis, 0);
    else chk(mis == 0, "R7 invalid row bits mismatched", mis, 0);
    repeat (60) @(negedge clk);
    chk(bitcnt == 80, "R5 bits per row", bitcnt, 80);
  endtask

  task automatic do_card(input int b, input bit stk, input int sd, input int div,
                         input bit bad_rows, input bit poke);
    int rc;
    tdiv = div; seed = sd; base_tb = b;
    fetch_cnt = 0; addr_bad = 0; width_bad = 0; done_cnt = 0;
    base_addr = 15'(b); stacker_in = stk; punch_err = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(punch_start == 1'b1, "R1 start level", punch_start, 1);
    chk(stacker_sel == stk, "R11 stacker captured", stacker_sel, stk);
    for (int r = 0; r < 12; r++) begin
      if (bad_rows) rc = (r % 4 == 0) ? 10 : 12 + r % 4;
      else rc = (r == 0) ? 12 : (r == 1) ? 11 : r - 2;
      if (poke && r == 3) begin
        base_addr = 15'(b + 200); stacker_in = ~stk;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(stacker_sel == stk, "R10 stacker after busy start", stacker_sel, stk);
        chk(punch_start == 1'b1, "R10 start level after busy start", punch_start, 1);
        chk(last_row == 1'b0, "R9 last row early", last_row, 0);
      end
      do_row(rc);
    end
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R9 done pulse count", done_cnt, 1);
    if (div == 1) chk(done_lat == 3, "R9 done latency", done_lat, 3);
    chk(last_row == 1'b1, "R9 last row flag", last_row, 1);
    chk(punch_start == 1'b0, "R9 start level after card", punch_start, 0);
    chk(card_err == 1'b0, "R2 error flag on good card", card_err, 0);
    chk(fetch_cnt == 120, "R4 fetches per card", fetch_cnt, 120);
    chk(addr_bad == 0, "R4 fetch addresses", addr_bad, 0);
    chk(width_bad == 0, "R8 clock pulse width", width_bad, 0);
    chk(stacker_sel == stk, "R11 stacker held", stacker_sel, stk);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int f0, b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({punch_start, punch_clk, mem_req, done, last_row, card_err} == 6'b0,
        "R1 reset outputs", {punch_start, punch_clk, mem_req, done, last_row, card_err}, 0);

    do_card(100, 1'b1, 0, 1, 1'b0, 1'b1);

    f0 = fetch_cnt; b0 = bitcnt;
    punch_err = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R2 done after error start", done, 1);
    chk(card_err == 1'b1, "R2 error flag", card_err, 1);
    repeat (30) @(negedge clk);
    chk(fetch_cnt == f0, "R2 no fetch on error", fetch_cnt, f0);
    chk(bitcnt == b0, "R2 no clock on error", bitcnt, b0);
    chk(punch_start == 1'b0, "R2 start level on error", punch_start, 0);
    punch_err = 1'b0;

    do_card(32000, 1'b0, 17, 3, 1'b0, 1'b0);
    do_card(5, 1'b1, 40, 1, 1'b1, 1'b0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule